// File: doc/BRIEF.md
# Backscatter Link-Frequency Divider

This block sets the tag-to-reader bit clock of a passive transponder. The receive path measures the tag-to-reader calibration symbol as a count of master clock periods. The query command then picks one of two divide ratios: eight, or the fractional ratio sixty-four thirds. From these the block computes, with round-to-nearest arithmetic, how many master clock cycles make up one backscatter period. The result is an integer, because the link clock can only be obtained by dividing the master clock by a whole number.

A load strobe latches the computed divisor. While the run enable is high, a down-counter turns the latched divisor into a train of one-cycle clock-enable pulses at the link frequency. An encoder for the reply can step on these pulses. The measured count may be off by one cycle in either direction, because the phase between the local oscillator and the received edges is unknown. Rounding the quotient absorbs most of that error. A clamp keeps the divisor at two or more, so the pulse output can never stay high.

Top module: `blf_divider`

## Requirements
- R1: Right after a synchronous reset, `div_o` reads 2 and `tick_o` is 0.
- R2: With `ratio_sel_i` = 0 (divide by eight), a cycle with `load_i` high sets `div_o`, from the next cycle on, to (count + 4) >> 3, the count being `trcal_cnt_i` in that cycle.
- R3: With `ratio_sel_i` = 1 (divide by 64/3), a load sets `div_o` to (3·count + 32) >> 6, with the same timing as R2.
- R4: A computed divisor of 0 or 1 is stored as 2, and the pulse train then alternates high and low.
- R5: While `run_i` stays high and no load occurs, `tick_o` is high for exactly one cycle in every `div_o` cycles. The first pulse appears one cycle after the first clock edge at which `run_i` is high.
- R6: While `run_i` is low, `tick_o` stays 0 and the period phase returns to its start.
- R7: A load restarts the phase. `tick_o` is 0 in the cycle after the load edge. If `run_i` is high, `tick_o` is 1 in the cycle after that.
- R8: Without a load, changes on `trcal_cnt_i` and `ratio_sel_i` leave `div_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| trcal_cnt_i | input | CNT_W (12) | Calibration symbol length in master clock periods |
| ratio_sel_i | input | 1 | Divide ratio: 0 selects 8, 1 selects 64/3 |
| load_i | input | 1 | Latches the computed divisor and restarts the phase |
| run_i | input | 1 | Enables the pulse train |
| div_o | output | CNT_W-2 (10) | Latched divisor, in master cycles per link period |
| tick_o | output | 1 | One-cycle clock enable at the link frequency |

## Verification
The divisor is registered, so it is due on the first clock edge after the load strobe. The bench raises the strobe on a falling edge and reads `div_o` on the next falling edge. The pulse output is also registered. The first pulse is due one edge after the edge that first sees `run_i` high, and later pulses follow every `div_o` edges. The bench therefore checks `tick_o` on each falling edge against a position computed from the divisor. After a load during a run, the bench expects one quiet cycle and then a pulse, which is two edges after the load.

// File: rtl/blf_pkg.sv
package blf_pkg;
  typedef enum logic {
    RATIO_EIGHT   = 1'b0,
    RATIO_64_OF_3 = 1'b1
  } ratio_e;

  localparam int unsigned MIN_DIV = 2;
endpackage

// File: rtl/blf_div_calc.sv
module blf_div_calc #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DIV_W = CNT_W - 2
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  blf_pkg::ratio_e  ratio_i,
  output logic [DIV_W-1:0] div_o
);
  localparam int unsigned SUM_W     = CNT_W + 3;
  localparam int unsigned SH_EIGHT  = 3;
  localparam int unsigned SH_FRAC   = 6;
  localparam int unsigned HALF_8    = 1 << (SH_EIGHT - 1);
  localparam int unsigned HALF_FRAC = 1 << (SH_FRAC - 1);

  logic [SUM_W-1:0] ext;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] quo;

  always_comb begin
    ext = SUM_W'(cnt_i);
    if (ratio_i == blf_pkg::RATIO_64_OF_3) begin
      sum = (ext << 1) + ext + SUM_W'(HALF_FRAC);
      quo = sum >> SH_FRAC;
    end else begin
      sum = ext + SUM_W'(HALF_8);
      quo = sum >> SH_EIGHT;
    end
    if (quo < SUM_W'(blf_pkg::MIN_DIV)) div_o = DIV_W'(blf_pkg::MIN_DIV);
    else                                div_o = quo[DIV_W-1:0];
  end
endmodule

// File: rtl/blf_tick_gen.sv
module blf_tick_gen #(
  parameter int unsigned DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i || !run_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= div_i - DIV_W'(1);
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - DIV_W'(1);
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/blf_divider.sv
module blf_divider #(
  parameter int unsigned CNT_W = 12,
  localparam int unsigned DIV_W = CNT_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] trcal_cnt_i,
  input  logic             ratio_sel_i,
  input  logic             load_i,
  input  logic             run_i,
  output logic [DIV_W-1:0] div_o,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_next;
  logic [DIV_W-1:0] div_q;

  blf_div_calc #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_calc (
    .cnt_i   (trcal_cnt_i),
    .ratio_i (blf_pkg::ratio_e'(ratio_sel_i)),
    .div_o   (div_next)
  );

  always_ff @(posedge clk) begin
    if (rst)         div_q <= DIV_W'(blf_pkg::MIN_DIV);
    else if (load_i) div_q <= div_next;
  end

  blf_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .restart_i (load_i),
    .run_i     (run_i),
    .div_i     (div_q),
    .tick_o    (tick_o)
  );

  assign div_o = div_q;
endmodule

// File: rtl/blf_divider_chk.sv
module blf_divider_chk #(
  parameter int unsigned DIV_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             load_i,
  input logic             run_i,
  input logic [DIV_W-1:0] div_o,
  input logic             tick_o
);
  logic [DIV_W:0] gap_q;
  logic           seen_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i || load_i) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick_o) begin
      gap_q  <= (DIV_W+1)'(1);
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + (DIV_W+1)'(1);
    end
  end

  // R4
  div_floor_chk: assert property (@(posedge clk) disable iff (rst)
    div_o >= DIV_W'(2));

  // R5
  tick_width_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  // R5
  tick_period_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && tick_o) |-> (gap_q == {1'b0, div_o}));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !tick_o);

  // R7
  load_restart_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !tick_o);

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(div_o));
endmodule

bind blf_divider blf_divider_chk #(.DIV_W(DIV_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .load_i (load_i),
  .run_i  (run_i),
  .div_o  (div_o),
  .tick_o (tick_o)
);

// File: tb/blf_divider_test.sv
`timescale 1ns/1ps
module blf_divider_test;
  localparam int CNT_W = 12;
  localparam int DIV_W = CNT_W - 2;
  localparam int NV    = 13;

  // {ratio select, count, expected divisor}
  localparam logic [22:0] VECS [NV] = '{
    {1'b0, 12'd0,    10'd2},
    {1'b0, 12'd11,   10'd2},
    {1'b0, 12'd12,   10'd2},
    {1'b0, 12'd83,   10'd10},
    {1'b0, 12'd84,   10'd11},
    {1'b0, 12'd100,  10'd13},
    {1'b0, 12'd4095, 10'd512},
    {1'b1, 12'd20,   10'd2},
    {1'b1, 12'd74,   10'd3},
    {1'b1, 12'd75,   10'd4},
    {1'b1, 12'd100,  10'd5},
    {1'b1, 12'd640,  10'd30},
    {1'b1, 12'd4095, 10'd192}
  };

  logic             clk = 1'b0;
  logic             rst;
  logic [CNT_W-1:0] trcal_cnt_i;
  logic             ratio_sel_i;
  logic             load_i;
  logic             run_i;
  logic [DIV_W-1:0] div_o;
  logic             tick_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  blf_divider #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .trcal_cnt_i(trcal_cnt_i), .ratio_sel_i(ratio_sel_i),
    .load_i(load_i), .run_i(run_i), .div_o(div_o), .tick_o(tick_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_div(input logic sel, input int cnt);
    @(negedge clk);
    ratio_sel_i = sel;
    trcal_cnt_i = CNT_W'(cnt);
    load_i      = 1'b1;
    @(negedge clk);
    load_i      = 1'b0;
  endtask

  initial begin
    rst = 1'b1; trcal_cnt_i = '0; ratio_sel_i = 1'b0; load_i = 1'b0; run_i = 1'b0;
    repeat (3) @(negedge clk);
    check(div_o == DIV_W'(2), "R1 divisor", int'(div_o), 2);
    check(tick_o == 1'b0, "R1 tick", int'(tick_o), 0);
    rst = 1'b0;

    // Table of divisor vectors (R2, R3, R4)
    for (int i = 0; i < NV; i++) begin
      load_div(VECS[i][22], int'(VECS[i][21:10]));
      check(div_o == VECS[i][9:0], VECS[i][22] ? "R3 ratio 64/3" : "R2 ratio 8",
            int'(div_o), int'(VECS[i][9:0]));
    end

    // R8: inputs move without a load
    @(negedge clk);
    trcal_cnt_i = 12'd400; ratio_sel_i = 1'b0;
    repeat (3) @(negedge clk);
    check(div_o == DIV_W'(192), "R8 hold", int'(div_o), 192);

    // R5: pulse train with divisor 5
    load_div(1'b0, 40);
    check(div_o == DIV_W'(5), "R2 divisor 5", int'(div_o), 5);
    run_i = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      check(tick_o == ((k % 5) == 0), "R5 tick position", int'(tick_o), int'((k % 5) == 0));
    end

    // R7: load in mid-period restarts the phase
    @(negedge clk);
    trcal_cnt_i = 12'd40; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    check(tick_o == 1'b0, "R7 quiet after load", int'(tick_o), 0);
    @(negedge clk);
    check(tick_o == 1'b1, "R7 tick after restart", int'(tick_o), 1);

    // R6: run low keeps the output quiet
    run_i = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        seen += int'(tick_o);
      end
      check(seen == 0, "R6 idle ticks", seen, 0);
    end

    // R4: clamped divisor gives an alternating train
    load_div(1'b1, 5);
    check(div_o == DIV_W'(2), "R4 clamp", int'(div_o), 2);
    run_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(tick_o == ((k % 2) == 0), "R4 alternating", int'(tick_o), int'((k % 2) == 0));
    end
    run_i = 1'b0;

    // R1: reset during activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(div_o == DIV_W'(2) && tick_o == 1'b0, "R1 reset again", int'(div_o), 2);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule